// File: doc/BRIEF.md
# Address Breakpoint Unit

This block sits beside a processor core and watches the core's 16-bit address bus. When the bus carries a valid address that equals a programmed match value, and breakpoints are enabled, the block raises an active-high breakpoint output. Software programs the match value through two byte-wide registers and sets the unit up through one control register. That control register also holds a sticky status flag that records a breakpoint.

The output works in one of two modes. In pulse mode each qualifying match drives the output high for a fixed number of clock cycles, eight by default. A match that arrives while a pulse is still running starts the count again. In level mode the output follows the sticky status flag and stays high until software clears the flag by writing a one to it. The pulse length is a number of cycles of whatever clock the unit runs on, not a fixed time.

Top module: `addr_brk_unit`

## Requirements
- R1: While rst_n is low, and after it is released, all three registers read 0x00 and brk_out is low.
- R2: Register offsets: 0 holds the low match byte and 1 holds the high match byte, both read/write. Offset 2 is control: bit 0 enable, bit 1 pulse mode, bit 7 status. Offset 3 reads 0x00. Writes take effect at the clock edge where reg_wr is high. reg_rdata shows the selected register in the same cycle.
- R3: A match needs cpu_addr_vld high and cpu_addr equal to {high byte, low byte}. Any other bus value, or a low valid strobe, leaves the status flag and brk_out unchanged.
- R4: While the enable bit is 0, a matching address leaves the status flag and brk_out unchanged.
- R5: In pulse mode (bit 1 = 1), a match sampled at a clock edge drives brk_out high for exactly 8 cycles, starting right after that edge.
- R6: In pulse mode, a match while brk_out is high reloads the count, so brk_out stays high for 8 cycles after the latest match.
- R7: In level mode (bit 1 = 0), brk_out follows the status flag and stays high until that flag is cleared.
- R8: Each qualifying match sets the status flag (control bit 7) in both modes, and the flag can be read back.
- R9: Writing the control register with bit 7 = 1 clears the status flag. Writing it with bit 7 = 0 leaves the flag set.
- R10: If a match and a clearing write fall in the same cycle, the status flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_addr | input | 16 | Processor address bus |
| cpu_addr_vld | input | 1 | Address bus valid qualifier |
| brk_out | output | 1 | Breakpoint output, active high |

## Verification
The hardest cases to reach from the ports are the ones where two events meet in a single cycle. One is a match that arrives while a pulse is already running. The other is a match that lands in the same cycle as a clearing write. For these, the bench drives the address bus and the register strobe together on one falling edge, and drives the repeat match a known number of cycles into the pulse. It then counts how many consecutive samples of brk_out are high and compares that count with the reload arithmetic. A match that differs only in its high byte, and a correct address with the valid strobe low, show that the comparison covers all 16 bits and is gated by the strobe.

// File: rtl/addr_brk_pkg.sv
package addr_brk_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned RADDR_W   = 2;
  localparam int unsigned PULSE_LEN = 8;

  localparam logic [RADDR_W-1:0] OFS_MATCH_LO = 2'd0;
  localparam logic [RADDR_W-1:0] OFS_MATCH_HI = 2'd1;
  localparam logic [RADDR_W-1:0] OFS_CTRL     = 2'd2;

  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_PULSE  = 1;
  localparam int unsigned BIT_STATUS = 7;
endpackage

// File: rtl/addr_brk_regs.sv
module addr_brk_regs
  import addr_brk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [RADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               hit_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [ADDR_W-1:0]  match_o,
  output logic               en_o,
  output logic               pulse_sel_o,
  output logic               status_o
);
  localparam int unsigned NBYTES = ADDR_W / DATA_W;

  logic [DATA_W-1:0] match_q [NBYTES];
  logic              en_q, en_d;
  logic              pulse_q, pulse_d;
  logic              stat_q, stat_d;
  logic              ctrl_wr;

  assign ctrl_wr = wr_i && (addr_i == OFS_CTRL);

  for (genvar b = 0; b < NBYTES; b++) begin : g_match_byte
    logic byte_wr;
    assign byte_wr = wr_i && (addr_i == RADDR_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       match_q[b] <= '0;
      else if (byte_wr) match_q[b] <= wdata_i;
    end
    assign match_o[b*DATA_W +: DATA_W] = match_q[b];
  end

  always_comb begin
    en_d    = en_q;
    pulse_d = pulse_q;
    stat_d  = stat_q;
    if (ctrl_wr) begin
      en_d    = wdata_i[BIT_EN];
      pulse_d = wdata_i[BIT_PULSE];
      if (wdata_i[BIT_STATUS]) stat_d = 1'b0;
    end
    if (hit_i) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      pulse_q <= pulse_d;
      stat_q  <= stat_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_MATCH_LO: rdata_o = match_q[0];
      OFS_MATCH_HI: rdata_o = match_q[1];
      OFS_CTRL: begin
        rdata_o[BIT_EN]     = en_q;
        rdata_o[BIT_PULSE]  = pulse_q;
        rdata_o[BIT_STATUS] = stat_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign en_o        = en_q;
  assign pulse_sel_o = pulse_q;
  assign status_o    = stat_q;

  // R9: a control write with bit 7 low keeps the flag set
  a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && ctrl_wr && !wdata_i[BIT_STATUS]) |=> stat_q);
  // R10: a match always leaves the flag set, even against a clear
  a_r10_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> stat_q);
endmodule

// File: rtl/addr_brk_match.sv
module addr_brk_match
  import addr_brk_pkg::*;
(
  input  logic [ADDR_W-1:0] bus_i,
  input  logic              vld_i,
  input  logic [ADDR_W-1:0] match_i,
  input  logic              en_i,
  output logic              hit_o
);
  localparam int unsigned NBYTES = ADDR_W / DATA_W;

  logic [NBYTES-1:0] byte_eq;

  for (genvar b = 0; b < NBYTES; b++) begin : g_cmp
    assign byte_eq[b] = (bus_i[b*DATA_W +: DATA_W] == match_i[b*DATA_W +: DATA_W]);
  end

  assign hit_o = en_i && vld_i && (&byte_eq);
endmodule

// File: rtl/addr_brk_timer.sv
module addr_brk_timer
  import addr_brk_pkg::*;
#(
  parameter int unsigned LEN = PULSE_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic load_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = !mode_i || load_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!mode_i)            cnt_d = '0;
    else if (load_i)        cnt_d = LOAD_VAL;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

  // R5: the count never exceeds the pulse length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL);
endmodule

// File: rtl/addr_brk_unit.sv
module addr_brk_unit
  import addr_brk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_addr_vld,
  output logic               brk_out
);
  logic [ADDR_W-1:0] match_addr;
  logic              en, pulse_sel, status, hit, pulse_on;

  addr_brk_regs u_regs (
    .clk, .rst_n,
    .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata), .hit_i(hit),
    .rdata_o(reg_rdata), .match_o(match_addr), .en_o(en),
    .pulse_sel_o(pulse_sel), .status_o(status)
  );

  addr_brk_match u_match (
    .bus_i(cpu_addr), .vld_i(cpu_addr_vld), .match_i(match_addr),
    .en_i(en), .hit_o(hit)
  );

  addr_brk_timer #(.LEN(PULSE_LEN)) u_timer (
    .clk, .rst_n, .mode_i(pulse_sel), .load_i(hit), .active_o(pulse_on)
  );

  assign brk_out = pulse_sel ? pulse_on : status;

  // R4: with breakpoints disabled the flag cannot rise
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(status));
  // R3: no valid matching address, no new flag
  a_r3_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_addr_vld && cpu_addr == match_addr) |=> !$rose(status));
  // R6: a qualifying match in pulse mode leaves the output high next cycle
  a_r6_pulse_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pulse_sel && !(reg_wr && reg_addr == OFS_CTRL)) |=> brk_out);
  // R7: level output holds while the control register is untouched
  a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_sel && brk_out && !(reg_wr && reg_addr == OFS_CTRL)) |=> brk_out);
endmodule

// File: tb/addr_brk_unit_tb_top.sv
module addr_brk_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] cpu_addr = '0;
  logic        cpu_addr_vld = 1'b0;
  logic        brk_out;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  addr_brk_unit dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup(input logic [15:0] m, input logic [7:0] ctrl);
    wr(2'd0, m[7:0]);
    wr(2'd1, m[15:8]);
    wr(2'd2, ctrl | 8'h80);
  endtask

  // Drive 'addr' with valid at the negedges listed in mask; count high samples
  task automatic run_seq(input logic [15:0] addr, input logic vld,
                         input logic [23:0] mask, output int highs);
    highs = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (i > 0 && brk_out) highs++;
      cpu_addr = addr;
      cpu_addr_vld = vld && mask[i];
    end
    cpu_addr_vld = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    setup(16'hA5C3, 8'h01);
    @(negedge clk); cpu_addr = 16'hA5C3; cpu_addr_vld = 1'b1;
    @(negedge clk); cpu_addr_vld = 1'b0;
    rst_n = 1'b0;
    #1 chk("R1 brk_out in reset", brk_out, 0);
    rd(2'd0, d); chk("R1 low byte", d, 0);
    rd(2'd1, d); chk("R1 high byte", d, 0);
    rd(2'd2, d); chk("R1 control", d, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 brk_out after release", brk_out, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(2'd0, 8'h3C); wr(2'd1, 8'hE1); wr(2'd2, 8'h03);
    rd(2'd0, d); chk("R2 low byte", d, 8'h3C);
    rd(2'd1, d); chk("R2 high byte", d, 8'hE1);
    rd(2'd2, d); chk("R2 control", d, 8'h03);
    rd(2'd3, d); chk("R2 offset 3", d, 0);
  endtask

  task automatic t_no_match;
    int h; logic [7:0] d;
    setup(16'h1234, 8'h03);
    run_seq(16'h1235, 1'b1, 24'h1, h); chk("R3 low byte differs", h, 0);
    run_seq(16'h9234, 1'b1, 24'h1, h); chk("R3 high byte differs", h, 0);
    run_seq(16'h1234, 1'b0, 24'h1, h); chk("R3 valid low", h, 0);
    rd(2'd2, d); chk("R3 status untouched", d[7], 0);
  endtask

  task automatic t_disabled;
    int h; logic [7:0] d;
    setup(16'h1234, 8'h02);
    run_seq(16'h1234, 1'b1, 24'h1, h); chk("R4 disabled pulse", h, 0);
    rd(2'd2, d); chk("R4 disabled status", d[7], 0);
    wr(2'd2, 8'h00);
    run_seq(16'h1234, 1'b1, 24'h1, h); chk("R4 disabled level", h, 0);
  endtask

  task automatic t_pulse;
    int h; logic [7:0] d;
    setup(16'hBEEF, 8'h03);
    run_seq(16'hBEEF, 1'b1, 24'h1, h); chk("R5 pulse length", h, 8);
    rd(2'd2, d); chk("R8 status in pulse mode", d, 8'h83);
    wr(2'd2, 8'h83);
    run_seq(16'hBEEF, 1'b1, 24'h9, h); chk("R6 restart at 3", h, 11);
    wr(2'd2, 8'h83);
    run_seq(16'hBEEF, 1'b1, 24'h101, h); chk("R6 restart at 8", h, 16);
  endtask

  task automatic t_level;
    int h; logic [7:0] d;
    setup(16'h0F0F, 8'h01);
    run_seq(16'h0F0F, 1'b1, 24'h1, h); chk("R7 level held", h, 23);
    rd(2'd2, d); chk("R8 status in level mode", d, 8'h81);
    wr(2'd2, 8'h01);
    chk("R9 write zero keeps output", brk_out, 1);
    rd(2'd2, d); chk("R9 write zero keeps status", d[7], 1);
    wr(2'd2, 8'h81);
    chk("R9 clear drops output", brk_out, 0);
    rd(2'd2, d); chk("R9 clear drops status", d[7], 0);
  endtask

  task automatic t_race;
    logic [7:0] d;
    setup(16'h4242, 8'h01);
    @(negedge clk); cpu_addr = 16'h4242; cpu_addr_vld = 1'b1;
    @(negedge clk); cpu_addr_vld = 1'b0;
    chk("R10 level set", brk_out, 1);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h81; cpu_addr_vld = 1'b1;
    @(negedge clk); reg_wr = 1'b0; cpu_addr_vld = 1'b0;
    chk("R10 hit beats clear output", brk_out, 1);
    rd(2'd2, d); chk("R10 hit beats clear status", d[7], 1);
    wr(2'd2, 8'h81);
    chk("R10 later clear works", brk_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_no_match();
    t_disabled();
    t_pulse();
    t_level();
    t_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule